// File: doc/BRIEF.md
# DMA Transfer Length Counter

This block holds the byte count for a storage controller's DMA engine. Software programs a 24-bit start count through three byte-wide registers. It then issues a command. A command that carries the DMA flag copies the start count into a running count register. In the same step it sizes the next burst and begins counting bytes down as the DMA interface accepts them. A programmed count of zero stands for 65536 bytes.

The burst is the smaller of the running length and a limit. In command phase the limit is a fixed command-buffer size of 32 bytes. Otherwise it is the magnitude of a signed remaining-transfer size supplied by the protocol side, and the sign of that size selects the direction. When the last byte of a burst is accepted, the block raises terminal count and an interrupt request. At that point it also clears the lower two bytes of the running count. A write to any count byte clears terminal count. A new DMA command issued mid-burst abandons the old burst and reloads.

Top module: `dma_xfer_counter`

## Requirements
- R1: After reset, start_count, cur_count, burst_left, busy, dma_on, tc, irq and dir_out are all zero.
- R2: A write with reg_sel 0, 1 or 2 stores reg_wdata into bits 7:0, 15:8 or 23:16 of start_count, visible the next cycle; reg_sel 3 changes nothing.
- R3: A write with reg_sel 0, 1 or 2 clears tc the next cycle, unless a completion sets it in that same cycle.
- R4: A command with cmd_dma set loads cur_count with start_count, or with 0x010000 when start_count is zero. It sets dma_on, clears irq, and sets dir_out to the sign bit of xfer_size.
- R5: With cmd_phase high at such a command, burst_left is loaded with the smaller of the loaded length and CMD_BURST (32).
- R6: With cmd_phase low, burst_left is loaded with the smaller of the loaded length and the magnitude of xfer_size.
- R7: Each byte_ack while busy lowers burst_left and cur_count by one; byte_ack while not busy changes nothing.
- R8: On the byte_ack that takes burst_left from 1 to 0, the next cycle shows busy 0, tc 1 and irq 1. cur_count bits 15:0 read zero and bits 23:16 keep their decremented value.
- R9: A DMA command whose burst works out to zero leaves busy 0 and at once sets tc and irq, with cur_count bits 15:0 cleared.
- R10: A command with cmd_dma clear sets dma_on to 0, stops the burst, clears irq and keeps cur_count.
- R11: A DMA command during a burst aborts it and reloads both counts; a command takes priority over a byte_ack in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Count register write strobe |
| reg_sel | input | 2 | Byte select: 0 low, 1 middle, 2 high, 3 none |
| reg_wdata | input | 8 | Write data |
| cmd_valid | input | 1 | Command strobe |
| cmd_dma | input | 1 | DMA flag of the command |
| cmd_phase | input | 1 | Bus is in command phase |
| xfer_size | input | SIZE_W | Signed remaining transfer size; negative is outgoing |
| byte_ack | input | 1 | DMA interface accepted one byte |
| start_count | output | 24 | Programmed start count |
| cur_count | output | 24 | Running transfer length |
| burst_left | output | 24 | Bytes left in the current burst |
| busy | output | 1 | Burst in progress |
| dma_on | output | 1 | DMA mode selected by the last command |
| tc | output | 1 | Terminal count status |
| irq | output | 1 | Interrupt request |
| dir_out | output | 1 | Direction latched at the last DMA command (1 outgoing) |

## Verification
Every output is a flop, so each result of a register write, command or byte_ack is due exactly one clock edge after the cycle that presents it, including completion flags and the cleared low count bytes. The bench drives each stimulus on a falling edge and holds it across one rising edge. It removes the stimulus on the next falling edge and reads the outputs there, half a period after the edge that should have changed them. Burst sizing is walked through a vector table, which covers the zero-means-65536 case, the command-phase clamp and both signs of xfer_size. Completion, abort and priority cases follow as directed sequences.

// File: rtl/dma_xfer_counter.sv
module dma_xfer_counter #(
  parameter int CMD_BURST = 32,
  parameter int SIZE_W    = 25
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_sel,
  input  logic [7:0]        reg_wdata,
  input  logic              cmd_valid,
  input  logic              cmd_dma,
  input  logic              cmd_phase,
  input  logic [SIZE_W-1:0] xfer_size,
  input  logic              byte_ack,
  output logic [23:0]       start_count,
  output logic [23:0]       cur_count,
  output logic [23:0]       burst_left,
  output logic              busy,
  output logic              dma_on,
  output logic              tc,
  output logic              irq,
  output logic              dir_out
);

  localparam logic [23:0] ZERO_LEN = 24'h010000;

  logic [7:0]        st_lo, st_mid, st_hi;
  logic [23:0]       eff_len, burst, cur_m1;
  logic [SIZE_W:0]   sz_ext, mag;
  logic [31:0]       lim32;
  logic              size_neg, cnt_wr, last_ack, start_dma, zero_burst;

  assign start_count = {st_hi, st_mid, st_lo};
  assign eff_len     = (start_count == 24'd0) ? ZERO_LEN : start_count;
  assign size_neg    = xfer_size[SIZE_W-1];
  assign sz_ext      = {size_neg, xfer_size};
  assign mag         = size_neg ? (~sz_ext + 1'b1) : sz_ext;
  assign lim32       = cmd_phase ? 32'(CMD_BURST) : 32'(mag);
  assign burst       = (32'(eff_len) < lim32) ? eff_len : lim32[23:0];
  assign cnt_wr      = reg_wr && (reg_sel != 2'd3);
  assign start_dma   = cmd_valid && cmd_dma;
  assign zero_burst  = (burst == 24'd0);
  assign last_ack    = !cmd_valid && busy && byte_ack && (burst_left == 24'd1);
  assign cur_m1      = cur_count - 24'd1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_lo <= '0;
      st_mid <= '0;
      st_hi <= '0;
    end else if (reg_wr) begin
      case (reg_sel)
        2'd0: st_lo <= reg_wdata;
        2'd1: st_mid <= reg_wdata;
        2'd2: st_hi <= reg_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_count  <= '0;
      burst_left <= '0;
      busy       <= 1'b0;
      dma_on     <= 1'b0;
      tc         <= 1'b0;
      irq        <= 1'b0;
      dir_out    <= 1'b0;
    end else begin
      if (cnt_wr) tc <= 1'b0;
      if (cmd_valid) begin
        irq    <= 1'b0;
        dma_on <= cmd_dma;
        if (cmd_dma) begin
          dir_out <= size_neg;
          if (zero_burst) begin
            cur_count  <= {eff_len[23:16], 16'h0000};
            burst_left <= '0;
            busy       <= 1'b0;
            tc         <= 1'b1;
            irq        <= 1'b1;
          end else begin
            cur_count  <= eff_len;
            burst_left <= burst;
            busy       <= 1'b1;
            tc         <= 1'b0;
          end
        end else begin
          busy <= 1'b0;
        end
      end else if (busy && byte_ack) begin
        burst_left <= burst_left - 24'd1;
        if (burst_left == 24'd1) begin
          cur_count <= {cur_m1[23:16], 16'h0000};
          busy      <= 1'b0;
          tc        <= 1'b1;
          irq       <= 1'b1;
        end else begin
          cur_count <= cur_m1;
        end
      end
    end
  end

  // R3: a count write clears terminal count unless a completion lands together
  p_wr_clears_tc_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr && !last_ack && !(start_dma && zero_burst) |=> !tc);

  // R7: one byte per accepted strobe
  p_dec_by_one_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy && byte_ack && !cmd_valid |=> burst_left == $past(burst_left) - 24'd1);

  // R7: idle counters hold
  p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !cmd_valid |=> $stable(burst_left) && $stable(cur_count));

  // R8: completion flags and cleared low bytes
  p_done_flags_r8: assert property (@(posedge clk) disable iff (!rst_n)
    last_ack |=> tc && irq && !busy && cur_count[15:0] == 16'h0000);

  // R5/R6: a running burst is never empty
  p_busy_nonzero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> burst_left != 24'd0);

  // R10: a non-DMA command ends DMA mode and the burst
  p_nondma_stop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_dma |=> !dma_on && !busy && !irq);

endmodule

// File: tb/dma_xfer_counter_tb_top.sv
module dma_xfer_counter_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 0, cmd_valid = 0, cmd_dma = 0, cmd_phase = 0, byte_ack = 0;
  logic [1:0] reg_sel = 0;
  logic [7:0] reg_wdata = 0;
  logic [24:0] xfer_size = 0;
  logic [23:0] start_count, cur_count, burst_left;
  logic busy, dma_on, tc, irq, dir_out;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  dma_xfer_counter dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .cmd_valid(cmd_valid), .cmd_dma(cmd_dma), .cmd_phase(cmd_phase), .xfer_size(xfer_size),
    .byte_ack(byte_ack), .start_count(start_count), .cur_count(cur_count),
    .burst_left(burst_left), .busy(busy), .dma_on(dma_on), .tc(tc), .irq(irq), .dir_out(dir_out));

  localparam int NV = 7;
  localparam int V_PROG [NV]  = '{32'h40, 32'h10, 32'h0, 32'h100, 32'h3, 32'h20000, 32'h8};
  localparam int V_PH   [NV]  = '{1, 1, 0, 0, 0, 0, 0};
  localparam int V_SIZE [NV]  = '{100, 0, 32'h20000, -5, 9, -32'h30000, 0};
  localparam int V_CUR  [NV]  = '{32'h40, 32'h10, 32'h10000, 32'h100, 32'h3, 32'h20000, 32'h0};
  localparam int V_BUR  [NV]  = '{32, 16, 32'h10000, 5, 3, 32'h20000, 0};
  localparam int V_DIR  [NV]  = '{0, 0, 0, 1, 0, 1, 0};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk); reg_wr = 1; reg_sel = sel; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic prog(input logic [23:0] v);
    wr(2'd0, v[7:0]); wr(2'd1, v[15:8]); wr(2'd2, v[23:16]);
  endtask

  task automatic cmd(input logic dma, input logic ph, input logic [24:0] sz, input logic ack);
    @(negedge clk); cmd_valid = 1; cmd_dma = dma; cmd_phase = ph; xfer_size = sz; byte_ack = ack;
    @(negedge clk); cmd_valid = 0; byte_ack = 0;
  endtask

  task automatic ack1();
    @(negedge clk); byte_ack = 1;
    @(negedge clk); byte_ack = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 start_count", start_count, 0); chk("R1 cur_count", cur_count, 0);
    chk("R1 burst_left", burst_left, 0);
    chk("R1 flags", {busy, dma_on, tc, irq, dir_out}, 0);
    rst_n = 1;

    prog(24'h123456);
    chk("R2 start_count", start_count, 32'h123456);
    wr(2'd3, 8'hFF);
    chk("R2 sel3 ignored", start_count, 32'h123456);

    for (int i = 0; i < NV; i++) begin
      prog(V_PROG[i][23:0]);
      cmd(1'b1, V_PH[i][0], V_SIZE[i][24:0], 1'b0);
      chk(V_PH[i] != 0 ? "R5 burst" : "R6 burst", burst_left, V_BUR[i]);
      chk("R4 cur_count", cur_count, V_CUR[i]);
      chk("R4 dir_out", dir_out, V_DIR[i]);
      chk("R4 dma_on", dma_on, 1);
      chk("R9 busy/tc/irq", {busy, tc, irq}, V_BUR[i] != 0 ? 3'b100 : 3'b011);
    end

    prog(24'h010005);
    cmd(1'b1, 1'b0, 25'd2, 1'b0);
    chk("R6 burst 2", burst_left, 2);
    ack1();
    chk("R7 burst_left", burst_left, 1); chk("R7 cur_count", cur_count, 32'h010004);
    chk("R7 tc low", tc, 0);
    ack1();
    chk("R8 busy/tc/irq", {busy, tc, irq}, 3'b011);
    chk("R8 cur_count", cur_count, 32'h010000);
    chk("R8 burst_left", burst_left, 0);
    ack1();
    chk("R7 idle ack cur", cur_count, 32'h010000);
    chk("R7 idle ack left", burst_left, 0);
    wr(2'd3, 8'h00);
    chk("R3 sel3 keeps tc", tc, 1);
    wr(2'd1, 8'h00);
    chk("R3 write clears tc", tc, 0);
    chk("R3 irq kept", irq, 1);

    cmd(1'b0, 1'b0, 25'd0, 1'b0);
    chk("R10 dma_on/irq", {dma_on, irq}, 2'b00);
    chk("R10 cur kept", cur_count, 32'h010000);

    prog(24'h000020);
    cmd(1'b1, 1'b0, 25'd10, 1'b0);
    ack1();
    chk("R11 pre abort", burst_left, 9);
    prog(24'h000007);
    cmd(1'b1, 1'b1, 25'd0, 1'b1);
    chk("R11 reload burst", burst_left, 7);
    chk("R11 reload cur", cur_count, 7);
    chk("R11 busy", busy, 1);

    cmd(1'b0, 1'b0, 25'd0, 1'b0);
    chk("R10 stop busy", busy, 0);
    ack1();
    chk("R10 ack after stop", burst_left, 7);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule